// File: doc/BRIEF.md
# Physically Tagged Cache Indexed by Page Offset

This block is a direct-mapped, write-through data cache. Its set index and word select are taken only from the bits of the virtual address that address translation leaves unchanged. The tag and data arrays can therefore be read in the same cycle in which an external translation unit turns the virtual page number into a physical page number. Each line stores the physical page number as its tag. A lookup compares that stored tag with the translated page number. It counts as a hit only when the translation unit also reported a valid mapping for that request.

Because the index comes from inside the page, the total capacity equals one page: 128 lines of 32 bytes for a 4 KB page. The CPU presents a request and holds it until the cache pulses a response. The translation unit drives its page number and a hit flag alongside the request.

A read miss fetches the whole line from memory, one word at a time, and then returns the requested word. Every write goes out to memory through a single-entry write buffer. A write that misses does not allocate a line. Any pending buffered write reaches memory before a line fill starts.

Top module: `vipt_cache`

## Requirements
- R1: After reset, `resp_valid` and `mem_req` are low, and every line is invalid, so the first read of any address reports `resp_hit`=0.
- R2: Virtual address bits 11:5 select the line and bits 4:2 select the 32-bit word. A line fill reads the physical addresses {tlb_ppn, vaddr[11:5], w, 2'b00} for w = 0..7, in ascending order.
- R3: A lookup whose sampled `tlb_hit` is 0 produces no response and no memory read. While the CPU holds the request, the cache retries, and it completes once `tlb_hit` becomes 1.
- R4: A read hit returns the stored word with `resp_hit`=1. The response appears on the second rising edge after the request is first sampled, and it causes no memory read.
- R5: A read miss returns the requested word from memory with `resp_hit`=0 after fetching the line. A later read of the same line hits.
- R6: Every write causes exactly one memory write of `req_wdata` to {tlb_ppn, vaddr[11:2], 2'b00}. A write hit (`resp_hit`=1) also updates the cached word. A write miss (`resp_hit`=0) leaves the line uncached, so a following read of it misses.
- R7: The write buffer holds one entry. A pending buffered write is issued to memory before the first read of any line fill, and no fill read is issued while the buffer is occupied.
- R8: Two physical pages that share a page offset map to the same line. A read of one after the other misses and evicts the older line.
- R9: Two virtual addresses with the same page offset that translate to the same physical page hit the same line.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present; held until `resp_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | VA_W (32) | Virtual byte address |
| req_wdata | input | DATA_W (32) | Write data |
| tlb_ppn | input | PA_W-PAGE_W (20) | Translated physical page number |
| tlb_hit | input | 1 | Translation valid for the current request |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Lookup found the line (only with `resp_valid`) |
| resp_rdata | output | DATA_W (32) | Read data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | PA_W (32) | Physical byte address |
| mem_wdata | output | DATA_W (32) | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the current memory access |
| mem_rdata | input | DATA_W (32) | Read data, valid with `mem_ack` |

## Verification
Some internal faults surface at the CPU side within two cycles of the request. A stale valid bit or a wrong tag compare shows up as a flipped `resp_hit` or a wrong `resp_rdata`, and a broken index or word select returns data from the wrong physical address. Other faults show first on the memory port. A bad fill counter appears during the fill as out-of-order or missing read addresses. A write buffer that loses its entry or drains too late appears as a missing memory write, or as a fill read that comes before the write, within a few cycles of the next miss. Translation misses are exercised by holding `tlb_hit` low, and the memory port is watched for reads during that window.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FILL  = 2'd3
  } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] line_vld;

  // tag RAM: synchronous read, no reset, so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end

  // valid bits live in flops so that reset can clear them at once
  always_ff @(posedge clk) begin
    if (rst) begin
      line_vld <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) line_vld[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= line_vld[rd_idx];
    end
  end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= word_mem[rd_addr];
  end
endmodule

// File: rtl/vipt_wbuf.sv
module vipt_wbuf #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      addr <= '0;
      data <= '0;
    end else if (push) begin
      full <= 1'b1;
      addr <= push_addr;
      data <= push_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [PA_W-PAGE_W-1:0]   tlb_ppn,
  input  logic                     tlb_hit,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic [DATA_W-1:0]        resp_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [PA_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic                     mem_ack,
  input  logic [DATA_W-1:0]        mem_rdata
);
  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int IDX_W  = PAGE_W - LINE_W;      // capacity is one page
  localparam int WORD_W = LINE_W - BYTE_W;
  localparam int WOFF_W = PAGE_W - BYTE_W;      // word address inside page
  localparam logic [WORD_W-1:0] LAST_WORD = '1;

  vipt_state_e st, ret_st;

  logic [WOFF_W-1:0] woff_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PPN_W-1:0]  ppn_q;
  logic              tlb_ok_q;
  logic [WORD_W-1:0] fill_cnt;

  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;
  assign idx_q  = woff_q[WOFF_W-1:WORD_W];
  assign word_q = woff_q[WORD_W-1:0];

  logic unused_vaddr;
  assign unused_vaddr = ^{req_vaddr[VA_W-1:PAGE_W], req_vaddr[BYTE_W-1:0]};

  logic in_idle, in_look, in_fill, in_drain;
  assign in_idle  = (st == ST_IDLE);
  assign in_look  = (st == ST_LOOK);
  assign in_fill  = (st == ST_FILL);
  assign in_drain = (st == ST_DRAIN);

  // ---------------- arrays ----------------
  logic [PPN_W-1:0]  tag_rd;
  logic              vld_rd;
  logic [DATA_W-1:0] data_rd;
  logic              lookup_hit;
  logic              fill_ack, fill_last;
  logic              wb_full, wb_push, wb_pop;
  logic [PA_W-1:0]   wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic              dwe;
  logic [WOFF_W-1:0] dwa;
  logic [DATA_W-1:0] dwd;

  assign lookup_hit = vld_rd && (tag_rd == ppn_q);
  assign fill_ack   = in_fill && mem_req && mem_ack;
  assign fill_last  = fill_ack && (fill_cnt == LAST_WORD);
  assign wb_push    = in_look && tlb_ok_q && wr_q && !wb_full;
  assign wb_pop     = in_drain && mem_req && mem_ack;

  assign dwe = fill_ack || (wb_push && lookup_hit);
  assign dwa = in_fill ? {idx_q, fill_cnt} : woff_q;
  assign dwd = in_fill ? mem_rdata : wdata_q;

  vipt_tag_store #(.IDX_W(IDX_W), .TAG_W(PPN_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (in_idle),
    .rd_idx   (req_vaddr[PAGE_W-1:LINE_W]),
    .wr_en    (fill_last),
    .wr_idx   (idx_q),
    .wr_tag   (ppn_q),
    .rd_tag   (tag_rd),
    .rd_valid (vld_rd)
  );

  vipt_data_store #(.ADDR_W(WOFF_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_en   (in_idle),
    .rd_addr (req_vaddr[PAGE_W-1:BYTE_W]),
    .wr_en   (dwe),
    .wr_addr (dwa),
    .wr_data (dwd),
    .rd_data (data_rd)
  );

  vipt_wbuf #(.AW(PA_W), .DW(DATA_W)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (wb_push),
    .push_addr ({ppn_q, woff_q, {BYTE_W{1'b0}}}),
    .push_data (wdata_q),
    .pop       (wb_pop),
    .full      (wb_full),
    .addr      (wb_addr),
    .data      (wb_data)
  );

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ret_st     <= ST_IDLE;
      woff_q     <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      ppn_q      <= '0;
      tlb_ok_q   <= 1'b0;
      fill_cnt   <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            woff_q   <= req_vaddr[PAGE_W-1:BYTE_W];
            wr_q     <= req_write;
            wdata_q  <= req_wdata;
            ppn_q    <= tlb_ppn;
            tlb_ok_q <= tlb_hit;
            st       <= ST_LOOK;
          end else if (wb_full) begin
            ret_st <= ST_IDLE;
            st     <= ST_DRAIN;
          end
        end
        ST_LOOK: begin
          if (!tlb_ok_q) begin
            ret_st <= ST_IDLE;
            st     <= wb_full ? ST_DRAIN : ST_IDLE;
          end else if (wr_q) begin
            if (wb_full) begin
              ret_st <= ST_LOOK;
              st     <= ST_DRAIN;
            end else begin
              resp_valid <= 1'b1;
              resp_hit   <= lookup_hit;
              st         <= ST_IDLE;
            end
          end else if (lookup_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_rdata <= data_rd;
            st         <= ST_IDLE;
          end else begin
            fill_cnt <= '0;
            ret_st   <= ST_FILL;
            st       <= wb_full ? ST_DRAIN : ST_FILL;
          end
        end
        ST_DRAIN: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= wb_addr;
            mem_wdata <= wb_data;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= ret_st;
          end
        end
        ST_FILL: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {ppn_q, idx_q, fill_cnt, {BYTE_W{1'b0}}};
          end else if (mem_ack) begin
            if (fill_cnt == word_q) resp_rdata <= mem_rdata;
            if (fill_cnt == LAST_WORD) begin
              mem_req    <= 1'b0;
              resp_valid <= 1'b1;
              st         <= ST_IDLE;
            end else begin
              fill_cnt <= fill_cnt + 1'b1;
              mem_addr <= {ppn_q, idx_q, fill_cnt + 1'b1, {BYTE_W{1'b0}}};
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [PA_W-1:0] mem_addr,
  input logic            look_q,
  input logic            tlb_ok_q,
  input logic            wb_full
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!resp_valid && !mem_req));

  a_r3_hit_needs_translation: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> ($past(look_q) && $past(tlb_ok_q)));

  a_r3_no_read_on_tlb_miss: assert property (@(posedge clk) disable iff (rst)
    (look_q && !tlb_ok_q) |=> !(mem_req && !mem_we));

  a_r5_hit_only_with_resp: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_valid);

  a_r7_fill_after_drain: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> !wb_full);

  a_r10_mem_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind vipt_cache vipt_cache_chk #(.PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .look_q     (in_look),
  .tlb_ok_q   (tlb_ok_q),
  .wb_full    (wb_full)
);

// File: tb/sim_vipt_cache.sv
module sim_vipt_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_wdata = '0;
  logic [19:0] tlb_ppn = '0;
  logic        tlb_hit = 1'b0;
  logic        resp_valid, resp_hit;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  vipt_cache u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .tlb_ppn(tlb_ppn),
    .tlb_hit(tlb_hit), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // ---------------- memory model ----------------
  logic [31:0] mstore [logic [31:0]];
  logic [31:0] rd_log [16];
  int          rd_op  [16];
  int          rd_n = 0, n_wr = 0, op_n = 0, wr_op = -1, lat = 0;
  logic [31:0] last_wr_addr = '0, last_wr_data = '0;

  function automatic logic [31:0] memval(input logic [31:0] a);
    if (mstore.exists(a)) return mstore[a];
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req && !rst) begin
        if (lat == 2) begin
          lat = 0;
          mem_ack <= 1'b1;
          if (mem_we) begin
            mstore[mem_addr] = mem_wdata;
            n_wr++;
            wr_op = op_n;
            last_wr_addr = mem_addr;
            last_wr_data = mem_wdata;
          end else begin
            mem_rdata <= memval(mem_addr);
            if (rd_n < 16) begin
              rd_log[rd_n] = mem_addr;
              rd_op[rd_n]  = op_n;
            end
            rd_n++;
          end
          op_n++;
        end else lat++;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic wr, input logic [31:0] va, input logic [31:0] wd,
                        input logic [19:0] ppn, output logic [31:0] rd,
                        output logic hit, output int cyc);
    req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
    tlb_ppn = ppn; tlb_hit = 1'b1;
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (resp_valid) break;
    end
    rd = resp_rdata; hit = resp_hit;
    if (!resp_valid) cyc = -1;
    req_valid = 1'b0; tlb_hit = 1'b0;
  endtask

  function automatic logic [31:0] pa(input logic [19:0] ppn, input logic [31:0] va);
    return {ppn, va[11:0]};
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_read_miss();
    logic [31:0] rd; logic hit; int cyc;
    rd_n = 0;
    access(1'b0, 32'h0000_1A44, '0, 20'h12345, rd, hit, cyc);
    chk("R1 first read misses", {31'd0, hit}, 32'd0);
    chk("R5 miss data", rd, memval(pa(20'h12345, 32'h1A44)));
    chk("R2 fill reads eight words", rd_n, 32'd8);
    for (int k = 0; k < 8; k++)
      chk("R2 fill address order", rd_log[k], 32'h1234_5A40 + 32'(k * 4));
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; logic hit; int cyc;
    idle(2);
    rd_n = 0;
    access(1'b0, 32'h7777_0A44, '0, 20'h12345, rd, hit, cyc);
    chk("R9 synonym hits", {31'd0, hit}, 32'd1);
    chk("R4 hit data", rd, memval(32'h1234_5A44));
    chk("R4 hit latency", cyc, 32'd2);
    idle(1);
    access(1'b0, 32'h0000_1A58, '0, 20'h12345, rd, hit, cyc);
    chk("R5 other word of filled line hits", {31'd0, hit}, 32'd1);
    chk("R4 other word data", rd, memval(32'h1234_5A58));
    chk("R4 no memory reads on hit", rd_n, 32'd0);
  endtask

  task automatic t_tlb_hold();
    logic seen = 1'b0;
    idle(2);
    rd_n = 0;
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 32'h0000_0300;
    tlb_ppn = 20'h22222; tlb_hit = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (resp_valid) seen = 1'b1;
    end
    chk("R3 no response without translation", {31'd0, seen}, 32'd0);
    chk("R3 no memory read without translation", rd_n, 32'd0);
    tlb_hit = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); @(negedge clk);
      if (resp_valid) break;
    end
    chk("R3 completes after translation", {31'd0, resp_valid}, 32'd1);
    chk("R3 data after translation", resp_rdata, memval(32'h2222_2300));
    req_valid = 1'b0; tlb_hit = 1'b0;
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; logic hit; int cyc; int w0;
    idle(2);
    w0 = n_wr;
    access(1'b1, 32'h0000_1A44, 32'hDEAD_BEEF, 20'h12345, rd, hit, cyc);
    chk("R6 write hit flagged", {31'd0, hit}, 32'd1);
    idle(10);
    chk("R6 one memory write", n_wr - w0, 32'd1);
    chk("R6 write address", last_wr_addr, 32'h1234_5A44);
    chk("R6 write data", last_wr_data, 32'hDEAD_BEEF);
    access(1'b0, 32'h0000_1A44, '0, 20'h12345, rd, hit, cyc);
    chk("R6 cached word updated", rd, 32'hDEAD_BEEF);
    chk("R6 updated word still hits", {31'd0, hit}, 32'd1);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; logic hit; int cyc;
    idle(2);
    access(1'b1, 32'h0000_0200, 32'h0BAD_F00D, 20'h55555, rd, hit, cyc);
    chk("R6 write miss flagged", {31'd0, hit}, 32'd0);
    idle(10);
    rd_n = 0;
    access(1'b0, 32'h0000_0200, '0, 20'h55555, rd, hit, cyc);
    chk("R6 no allocate on write miss", {31'd0, hit}, 32'd0);
    chk("R6 written data from memory", rd, 32'h0BAD_F00D);
    chk("R6 line fetched after write miss", rd_n, 32'd8);
  endtask

  task automatic t_wb_order();
    logic [31:0] rd; logic hit; int cyc; int w0;
    idle(10);
    w0 = n_wr; rd_n = 0;
    access(1'b1, 32'h0000_0604, 32'hCAFE_0001, 20'h33333, rd, hit, cyc);
    access(1'b0, 32'h0000_0708, '0, 20'h44444, rd, hit, cyc);
    chk("R7 buffered write issued", n_wr - w0, 32'd1);
    chk("R7 buffered write address", last_wr_addr, 32'h3333_3604);
    chk("R7 write before first fill read", {31'd0, (wr_op < rd_op[0])}, 32'd1);
    chk("R7 fill data after drain", rd, memval(32'h4444_4708));
  endtask

  task automatic t_conflict();
    logic [31:0] rd; logic hit; int cyc;
    idle(2);
    access(1'b0, 32'h0000_0A44, '0, 20'h0BEEF, rd, hit, cyc);
    chk("R8 other page same offset misses", {31'd0, hit}, 32'd0);
    chk("R8 data from new page", rd, memval(32'h0BEE_FA44));
    idle(1);
    access(1'b0, 32'h0000_1A44, '0, 20'h12345, rd, hit, cyc);
    chk("R8 evicted line misses", {31'd0, hit}, 32'd0);
    chk("R8 refetched data", rd, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_read_miss();
    t_read_hit();
    t_tlb_hold();
    t_write_hit();
    t_write_miss();
    t_wb_order();
    t_conflict();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule